// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

The block is a general-purpose 16-bit up-counter with a small register port and one interrupt line. A programmable prescaler divides the system clock. On every prescaled tick the counter advances toward a programmed reference value. When the count equals the reference on a tick, the block raises a sticky reference event flag. That flag drives the interrupt line when the interrupt enable in the mode register is set.

Software reaches four 16-bit registers over a byte-enabled write port and a combinational read port. The registers are the mode register, the reference register, the live counter and the event register. Counting needs the run bit in the mode register held at 1 and the clock-source field set to the divided system clock. Clearing the run bit in a write returns the whole block to its reset state. The counter can either restart from zero on a match or carry on past the reference and wrap at 0xFFFF.

Top module: `refcmp_timer`

## Requirements
- R1: After reset the registers read as follows: mode 0x0000, reference 0xFFFF, counter 0x0000, event 0x0000. The interrupt output is low. The register addresses are 0 for mode, 1 for reference, 2 for counter and 3 for event.
- R2: While mode bit 0 (run) is 0 the counter holds its value.
- R3: With the block running, the counter advances once every (mode[15:8] + 1) clock cycles.
- R4: Mode bits [2:1] select the clock source. Only 2'b01 (divided system clock) lets the counter advance. With 2'b00, 2'b10 or 2'b11 the counter stays still, even when run is 1.
- R5: Mode bit 3 enables restart on reference. With it set, a tick on which the counter equals the reference loads 0 into the counter and sets the event flag on that same tick.
- R6: With mode bit 3 clear, a tick at the reference value sets the flag and the counter still increments. The counter wraps from 0xFFFF to 0x0000.
- R7: The interrupt output is 1 exactly when mode bit 4 (interrupt enable) is 1 and event bit 0 (reference flag) is 1.
- R8: Writing 1 to event bit 0 clears the flag and writing 0 leaves it unchanged. A reference hit in the same cycle as a clear wins, so the flag stays set.
- R9: A write to the counter register loads the written value into the counter. This write takes priority over a tick in the same cycle.
- R10: A mode write that changes bit 0 from 1 to 0 returns every register to its R1 value.
- R11: Byte enable bit 0 selects data bits [7:0] and byte enable bit 1 selects bits [15:8]. Bytes whose enable is low keep their old value.
- R12: Every mode write restarts the prescaler phase. The first tick after the write comes mode[15:8] + 1 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for read and write |
| be | input | 2 | Byte enables for the write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Reference interrupt |

## Verification
The hardest case to reach is a write-one-to-clear of the event flag that lands on the same clock edge as a new reference hit. The stimulus sets the prescaler to divide by one with a short reference so that hits recur every few cycles. It then issues clear writes back to back for many cycles, so their phase sweeps across the hit edges. A behavioural model compares the interrupt line on every cycle and exposes a collision handled the wrong way. A second hard case is a stream of mode writes arriving faster than the prescale period. It shows that the prescaler phase restarts and the counter never advances.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_REF  = 2'd1,
    ADDR_CNT  = 2'd2,
    ADDR_EVT  = 2'd3
  } tmr_addr_e;

  localparam int MB_RUN     = 0;
  localparam int MB_SRC_LO  = 1;
  localparam int MB_RESTART = 3;
  localparam int MB_IEN     = 4;
  localparam int EB_REF     = 0;

  localparam logic [1:0] SRC_SYSDIV = 2'b01;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           sync_clr,
  input  logic [PSW-1:0] div,
  output logic           tick
);
  logic [PSW-1:0] phase;

  assign tick = run && (phase == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     phase <= '0;
    else if (sync_clr || !run)      phase <= '0;
    else if (tick)                  phase <= '0;
    else                            phase <= phase + 1'b1;
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (phase <= div)); // R3

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && !sync_clr) |=> !tick); // R3

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (phase == '0)); // R12
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] ref_val,
  input  logic          restart_en,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          clr,
  output logic [DW-1:0] count,
  output logic          ref_hit
);
  function automatic logic [DW-1:0] step(input logic [DW-1:0] cur,
                                         input logic hit, input logic rs);
    if (hit && rs) return '0;
    return cur + 1'b1;
  endfunction

  assign ref_hit = tick && (count == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (load)   count <= load_val;
    else if (tick)   count <= step(count, ref_hit, restart_en);
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !clr) |=> $stable(count)); // R2

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && restart_en && !load && !clr) |=> (count == '0)); // R5

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (count == $past(load_val))); // R9

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(ref_hit && restart_en) && !load && !clr)
      |=> (count == $past(count) + 1'b1)); // R6
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NB  = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [NB-1:0] be,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] count,
  input  logic          ref_hit,
  output logic [DW-1:0] mode,
  output logic [DW-1:0] ref_val,
  output logic          ref_flag,
  output logic          cnt_load,
  output logic [DW-1:0] cnt_load_val,
  output logic          mode_wr,
  output logic          soft_rst
);
  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v,
                                          input logic [DW-1:0] new_v,
                                          input logic [NB-1:0] en);
    logic [DW-1:0] r;
    r = old_v;
    for (int b = 0; b < NB; b++)
      if (en[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction

  logic [DW-1:0] mode_next;
  logic          wr_ref, wr_evt, evt_clear;

  assign mode_wr      = wr_en && (addr == ADDR_MODE);
  assign wr_ref       = wr_en && (addr == ADDR_REF);
  assign wr_evt       = wr_en && (addr == ADDR_EVT);
  assign cnt_load     = wr_en && (addr == ADDR_CNT);
  assign mode_next    = merge(mode, wdata, be);
  assign cnt_load_val = merge(count, wdata, be);
  assign soft_rst     = mode_wr && mode[MB_RUN] && !mode_next[MB_RUN];
  assign evt_clear    = wr_evt && be[0] && wdata[EB_REF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= '0;
      ref_val  <= '1;
      ref_flag <= 1'b0;
    end else if (soft_rst) begin
      mode     <= '0;
      ref_val  <= '1;
      ref_flag <= 1'b0;
    end else begin
      if (mode_wr) mode    <= mode_next;
      if (wr_ref)  ref_val <= merge(ref_val, wdata, be);
      if (ref_hit)        ref_flag <= 1'b1;
      else if (evt_clear) ref_flag <= 1'b0;
    end
  end

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode == '0 && ref_val == '1 && !ref_flag)); // R10

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && !soft_rst) |=> ref_flag); // R8

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_flag) |-> $past(ref_hit)); // R5

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clear && !ref_hit) |=> !ref_flag); // R8
endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
  import tmr_pkg::*;
#(
  parameter int DW  = 16,
  parameter int PSW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DW/8-1:0]   be,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  localparam int NB = DW / 8;

  logic [DW-1:0]  mode, ref_val, count, cnt_load_val;
  logic           ref_flag, cnt_load, mode_wr, soft_rst;
  logic           run, tick, ref_hit;
  logic [PSW-1:0] div;

  assign run = mode[MB_RUN] && (mode[MB_SRC_LO +: 2] == SRC_SYSDIV);
  assign div = mode[DW-1 -: PSW];

  tmr_regs #(.DW(DW), .NB(NB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .be(be),
    .wdata(wdata), .count(count), .ref_hit(ref_hit), .mode(mode),
    .ref_val(ref_val), .ref_flag(ref_flag), .cnt_load(cnt_load),
    .cnt_load_val(cnt_load_val), .mode_wr(mode_wr), .soft_rst(soft_rst)
  );

  tmr_prescaler #(.PSW(PSW)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .sync_clr(mode_wr),
    .div(div), .tick(tick)
  );

  tmr_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ref_val(ref_val),
    .restart_en(mode[MB_RESTART]), .load(cnt_load),
    .load_val(cnt_load_val), .clr(soft_rst), .count(count),
    .ref_hit(ref_hit)
  );

  always_comb begin
    unique case (addr)
      ADDR_MODE: rdata = mode;
      ADDR_REF:  rdata = ref_val;
      ADDR_CNT:  rdata = count;
      default:   rdata = {{(DW-1){1'b0}}, ref_flag};
    endcase
  end

  assign irq = mode[MB_IEN] & ref_flag;

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load && !soft_rst) |=> $stable(count)); // R4

  AST_IRQ_FOLLOWS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !irq); // R7
endmodule

// File: tb/test_refcmp_timer.sv
module test_refcmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic [1:0]  be = 2'b00;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  refcmp_timer i_refcmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // behavioural model state
  logic [15:0] m_mode = 16'h0000, m_ref = 16'hFFFF, m_cnt = 16'h0000;
  logic        m_flag = 1'b0;
  int          m_pc = 0;

  function automatic logic [15:0] bmask(input logic [1:0] en);
    return (en[1] ? 16'hFF00 : 16'h0000) | (en[0] ? 16'h00FF : 16'h0000);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 16'h0000; m_ref = 16'hFFFF; m_cnt = 16'h0000;
      m_flag = 1'b0; m_pc = 0;
    end else begin
      bit running, tk, hit;
      logic [15:0] nm, nc, nr, mk;
      logic nf;
      int np;
      running = m_mode[0] && (m_mode[2:1] == 2'b01);
      tk  = running && (m_pc == int'(m_mode[15:8]));
      hit = tk && (m_cnt == m_ref);
      nc = m_cnt; nm = m_mode; nr = m_ref; nf = m_flag;
      np = (!running || tk) ? 0 : m_pc + 1;
      if (tk) nc = (hit && m_mode[3]) ? 16'h0000 : m_cnt + 16'h0001;
      mk = bmask(be);
      if (wr_en && addr == 2'd3 && be[0] && wdata[0]) nf = 1'b0;
      if (hit) nf = 1'b1;
      if (wr_en && addr == 2'd1) nr = (m_ref & ~mk) | (wdata & mk);
      if (wr_en && addr == 2'd2) nc = (m_cnt & ~mk) | (wdata & mk);
      if (wr_en && addr == 2'd0) begin
        nm = (m_mode & ~mk) | (wdata & mk);
        np = 0;
        if (m_mode[0] && !nm[0]) begin
          nm = 16'h0000; nr = 16'hFFFF; nc = 16'h0000; nf = 1'b0;
        end
      end
      m_mode = nm; m_ref = nr; m_cnt = nc; m_flag = nf; m_pc = np;
    end
  end

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_mode;
      2'd1: return m_ref;
      2'd2: return m_cnt;
      default: return {15'd0, m_flag};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("MODEL rdata (R3,R5,R6,R9)", rdata, m_read(addr));
      chk("MODEL irq (R7,R8)", {15'd0, irq}, {15'd0, m_mode[4] & m_flag});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] e);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d; be = e;
    @(negedge clk); #1;
    wr_en = 1'b0; addr = 2'd2; be = 2'b00;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); #1;
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rd(2'd0, 16'h0000, "R1 mode");
    rd(2'd1, 16'hFFFF, "R1 ref");
    rd(2'd2, 16'h0000, "R1 count");
    rd(2'd3, 16'h0000, "R1 event");
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 stopped while run=0, R9 load
    wr(2'd0, 16'h0002, 2'b11);
    wr(2'd2, 16'h0007, 2'b11);
    idle(10);
    rd(2'd2, 16'h0007, "R2 count held, R9 load");

    // R4 unsupported sources
    wr(2'd1, 16'h1234, 2'b11);
    wr(2'd0, 16'h0001, 2'b11);
    idle(10);
    rd(2'd2, 16'h0007, "R4 source 00 stopped");
    wr(2'd0, 16'h0007, 2'b11);
    idle(10);
    rd(2'd2, 16'h0007, "R4 source 11 stopped");
    wr(2'd0, 16'h0005, 2'b11);
    idle(10);
    rd(2'd2, 16'h0007, "R4 source 10 stopped");

    // R10 soft reset via 1->0 on run
    wr(2'd0, 16'h0004, 2'b11);
    rd(2'd1, 16'hFFFF, "R10 ref reset");
    rd(2'd2, 16'h0000, "R10 count reset");
    rd(2'd0, 16'h0000, "R10 mode reset");

    // R3 / R5 / R7 : prescale 3, ref 5, restart, irq enable
    wr(2'd1, 16'h0005, 2'b11);
    wr(2'd0, 16'h021B, 2'b11);
    idle(7);
    rd(2'd2, 16'h0002, "R3 count after 7 cycles at div 3");
    for (int i = 0; i < 100 && !irq; i++) @(negedge clk);
    chk("R5 irq raised at match", {15'd0, irq}, 16'h0001);
    rd(2'd2, 16'h0000, "R5 restart to zero on hit tick");
    wr(2'd3, 16'h0000, 2'b11);
    rd(2'd3, 16'h0001, "R8 write 0 keeps flag");
    wr(2'd0, 16'h020B, 2'b11);
    chk("R7 irq low when disabled", {15'd0, irq}, 16'h0000);
    rd(2'd3, 16'h0001, "R7 flag still set");
    wr(2'd3, 16'h0001, 2'b11);
    rd(2'd3, {15'd0, m_flag}, "R8 w1c");

    // R12 mode writes restart the prescaler phase
    wr(2'd0, 16'h040B, 2'b11);
    @(negedge clk); #1 addr = 2'd2;
    #1 snap = rdata;
    for (int i = 0; i < 10; i++) wr(2'd0, 16'h040B, 2'b11);
    rd(2'd2, snap, "R12 count frozen by repeated mode writes");

    // R6 no restart, wrap
    wr(2'd0, 16'h0000, 2'b11);
    wr(2'd1, 16'h0003, 2'b11);
    wr(2'd2, 16'hFFFD, 2'b11);
    wr(2'd0, 16'h0013, 2'b11);
    idle(12);
    rd(2'd3, 16'h0001, "R6 flag set passing ref");
    @(negedge clk); #1 addr = 2'd2;
    #1 chk("R6 counted past ref", {15'd0, (rdata > 16'h0003 && rdata < 16'h0020)}, 16'h0001);

    // R11 byte enables
    wr(2'd0, 16'h0000, 2'b11);
    wr(2'd1, 16'h12CD, 2'b10);
    rd(2'd1, 16'h12FF, "R11 high byte only");
    wr(2'd1, 16'h3456, 2'b01);
    rd(2'd1, 16'h1256, "R11 low byte only");

    // R8 clear vs hit collision sweep
    wr(2'd1, 16'h0002, 2'b11);
    wr(2'd0, 16'h001B, 2'b11);
    for (int i = 0; i < 30; i++) wr(2'd3, 16'h0001, 2'b01);
    idle(5);
    rd(2'd3, {15'd0, m_flag}, "R8 flag after collision sweep");

    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule